// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block controls a bank of general-purpose pins through a small 32-bit register bus. Each pin has its own output enable, output value and output inversion, a pull-up enable, and an input enable. Each pin can also be marked as driven from outside the chip. On every clock edge the block works out the level of every pin and samples it into a read-only level register.

The sampled levels feed four kinds of sticky pending flags per pin: level high, level low, rising edge and falling edge. Each kind has its own enable mask. Software clears pending flags by writing ones to them. A pin's interrupt line is high when any of its pending flags is also enabled. The drive-strength and alternate-function registers are storage only and affect nothing else.

A host reads and writes the registers through a one-cycle select/write strobe. Read data is combinational from the addressed register. The pad drive, the pad enables, the per-pin interrupts and a per-pin contention flag leave the block as plain vectors.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: When a pin has its output enable set and is not externally driven, its pad output equals output value XOR output inversion. This shows one clock after the configuration is written. `pad_oe` always equals the output enable register.
- R2: A pin's resolved level follows a fixed priority: the external input when the pin is marked externally driven, else the internal drive when output enable is set, else the pull-up enable bit.
- R3: Each bit of the level register (offset 0x00) is input enable AND resolved level, registered once per clock. The register is read-only, and a write to 0x00 leaves it unchanged.
- R4: A high-pending bit is set whenever the sampled input is 1, and a low-pending bit whenever it is 0. Both stay set until cleared.
- R5: A rise-pending bit is set when the newly sampled input is 1 and the previously registered level is 0. A fall-pending bit is set in the opposite case. Both are sticky.
- R6: Writing a pending register clears exactly the bits written as 1; bits written as 0 are untouched. If a clear and a new detection hit the same bit in the same cycle, the bit stays set.
- R7: `irq[i]` is the OR over the four kinds of (pending bit i AND enable bit i).
- R8: The pad output of a pin is loaded only while its output enable is set. Otherwise it holds its last value. When the pin is externally driven and enabled, the pad output carries the external value.
- R9: Synchronous reset clears every register, the stored levels, all pending bits and the pad outputs.
- R10: Drive-strength, alternate-enable and alternate-select registers read back what was written. A read of an unmapped or misaligned offset returns 0, and a write there changes no register.
- R11: `pin_short[i]` is high exactly when output enable i and `pin_ext[i]` are both high.
- R12: Byte offsets are as follows:
  - 0x00 level, 0x04 input enable, 0x08 output enable, 0x0C output value, 0x10 output inversion, 0x14 pull-up, 0x18 drive strength, 0x1C alternate enable, 0x20 alternate select;
  - event kind k (0 high, 1 low, 2 rise, 3 fall) has its enable at 0x24+8k and its pending register at 0x28+8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| pin_in | input | NUM_PINS | External level per pin |
| pin_ext | input | NUM_PINS | Pin is driven externally |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |
| irq | output | NUM_PINS | Per-pin interrupt |
| pin_short | output | NUM_PINS | Output enabled while externally driven |

## Verification
The bench turns a pin's output enable off after the pad has been driven to 1. A design that reloads the pad every cycle would drop that pad to the pull level instead of holding it. The bench also clears a pending bit whose condition is still true and reads it in the very next cycle. A design that gives the clear priority shows a transient 0 there. Rising and falling edges are checked against the registered previous level, so a design comparing against the unregistered input would never flag them. Writes of zeros to pending registers, writes to the read-only level register and writes to an unmapped offset are each followed by readback, to catch decoders that alias or clear too much.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int NUM_EV = 4;

    typedef enum logic [1:0] {
        EV_HIGH = 2'd0,
        EV_LOW  = 2'd1,
        EV_RISE = 2'd2,
        EV_FALL = 2'd3
    } ev_kind_e;

    localparam logic [ADDR_W-1:0] OFS_LEVEL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IN_EN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OUT_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT_VAL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_OUT_INV = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_PULL    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DRIVE   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ALT_EN  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_ALT_SEL = 8'h20;
    localparam int                OFS_EV_BASE = 32'h24;
    localparam int                EV_STRIDE   = 8;

    typedef struct packed {
        logic in_en;
        logic out_en;
        logic out_val;
        logic out_inv;
        logic pull_en;
    } pin_cfg_t;

    function automatic logic [ADDR_W-1:0] ev_en_ofs(input int k);
        return ADDR_W'(OFS_EV_BASE + k * EV_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] ev_pend_ofs(input int k);
        return ADDR_W'(OFS_EV_BASE + k * EV_STRIDE + 4);
    endfunction

    function automatic logic pin_drive(input pin_cfg_t c);
        return c.out_en & (c.out_val ^ c.out_inv);
    endfunction

    function automatic logic pin_resolve(input pin_cfg_t c, input logic ext,
                                         input logic ext_val);
        logic lvl;
        if (ext)           lvl = ext_val;
        else if (c.out_en) lvl = pin_drive(c);
        else               lvl = c.pull_en;
        return lvl;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               bus_sel,
    input  logic                               bus_wr,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    output logic [DATA_W-1:0]                  bus_rdata,
    output logic [NUM_PINS-1:0]                in_en_q,
    output logic [NUM_PINS-1:0]                out_en_q,
    output logic [NUM_PINS-1:0]                out_val_q,
    output logic [NUM_PINS-1:0]                out_inv_q,
    output logic [NUM_PINS-1:0]                pull_en_q,
    output logic [NUM_EV-1:0][NUM_PINS-1:0]    ev_en_q,
    output logic [NUM_EV-1:0][NUM_PINS-1:0]    ev_clr,
    input  logic [NUM_PINS-1:0]                level_q,
    input  logic [NUM_EV-1:0][NUM_PINS-1:0]    ev_pend
);

    logic                wr_en;
    logic                rd_en;
    logic [NUM_PINS-1:0] wword;
    logic [NUM_PINS-1:0] drive_q;
    logic [NUM_PINS-1:0] alt_en_q;
    logic [NUM_PINS-1:0] alt_sel_q;
    logic [NUM_PINS-1:0] rd_word;
    logic                rd_hit;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;
    assign wword = bus_wdata[NUM_PINS-1:0];

    // Plain configuration and storage-only registers
    always_ff @(posedge clk) begin
        if (rst) begin
            in_en_q   <= '0;
            out_en_q  <= '0;
            out_val_q <= '0;
            out_inv_q <= '0;
            pull_en_q <= '0;
            drive_q   <= '0;
            alt_en_q  <= '0;
            alt_sel_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_IN_EN:   in_en_q   <= wword;
                OFS_OUT_EN:  out_en_q  <= wword;
                OFS_OUT_VAL: out_val_q <= wword;
                OFS_OUT_INV: out_inv_q <= wword;
                OFS_PULL:    pull_en_q <= wword;
                OFS_DRIVE:   drive_q   <= wword;
                OFS_ALT_EN:  alt_en_q  <= wword;
                OFS_ALT_SEL: alt_sel_q <= wword;
                default: ;
            endcase
        end
    end

    // Per-kind enable registers and write-one-to-clear strobes
    for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst)
                ev_en_q[k] <= '0;
            else if (wr_en && bus_addr == ev_en_ofs(k))
                ev_en_q[k] <= wword;
        end
        assign ev_clr[k] = (wr_en && bus_addr == ev_pend_ofs(k)) ? wword : '0;
    end

    // Read multiplexer
    always_comb begin
        rd_word = '0;
        rd_hit  = 1'b1;
        case (bus_addr)
            OFS_LEVEL:   rd_word = level_q;
            OFS_IN_EN:   rd_word = in_en_q;
            OFS_OUT_EN:  rd_word = out_en_q;
            OFS_OUT_VAL: rd_word = out_val_q;
            OFS_OUT_INV: rd_word = out_inv_q;
            OFS_PULL:    rd_word = pull_en_q;
            OFS_DRIVE:   rd_word = drive_q;
            OFS_ALT_EN:  rd_word = alt_en_q;
            OFS_ALT_SEL: rd_word = alt_sel_q;
            default:     rd_hit  = 1'b0;
        endcase
        for (int k = 0; k < NUM_EV; k++) begin
            if (bus_addr == ev_en_ofs(k)) begin
                rd_word = ev_en_q[k];
                rd_hit  = 1'b1;
            end
            if (bus_addr == ev_pend_ofs(k)) begin
                rd_word = ev_pend[k];
                rd_hit  = 1'b1;
            end
        end
    end

    assign bus_rdata = rd_en ? DATA_W'(rd_word) : '0;

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_hit) |-> (bus_rdata == '0)); // R10

    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(out_en_q) && $stable(in_en_q) && $stable(pull_en_q))); // R10

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     ext,
    input  logic     ext_val,
    output logic     pad_q,
    output logic     short_flag,
    output logic     sample_now,
    output logic     level_q
);

    logic resolved;

    assign resolved   = pin_resolve(cfg, ext, ext_val);
    assign sample_now = cfg.in_en & resolved;
    assign short_flag = cfg.out_en & ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_q   <= 1'b0;
            level_q <= 1'b0;
        end else begin
            level_q <= sample_now;
            if (cfg.out_en)
                pad_q <= resolved;
        end
    end

    AST_PAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg.out_en |=> $stable(pad_q)); // R8

    AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (rst)
        !cfg.in_en |=> !level_q); // R3

endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_PINS-1:0]             sample_now,
    input  logic [NUM_PINS-1:0]             level_q,
    input  logic [NUM_EV-1:0][NUM_PINS-1:0] ev_en,
    input  logic [NUM_EV-1:0][NUM_PINS-1:0] ev_clr,
    output logic [NUM_EV-1:0][NUM_PINS-1:0] ev_pend,
    output logic [NUM_PINS-1:0]             irq
);

    logic [NUM_EV-1:0][NUM_PINS-1:0] ev_set;

    for (genvar k = 0; k < NUM_EV; k++) begin : g_kind
        if (k == int'(EV_HIGH)) begin : g_high
            assign ev_set[k] = sample_now;
        end else if (k == int'(EV_LOW)) begin : g_low
            assign ev_set[k] = ~sample_now;
        end else if (k == int'(EV_RISE)) begin : g_rise
            assign ev_set[k] = sample_now & ~level_q;
        end else begin : g_fall
            assign ev_set[k] = ~sample_now & level_q;
        end

        // Detection has priority over a same-cycle clear
        always_ff @(posedge clk) begin
            if (rst)
                ev_pend[k] <= '0;
            else
                ev_pend[k] <= (ev_pend[k] & ~ev_clr[k]) | ev_set[k];
        end

        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
            AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
                (ev_pend[k][i] && !ev_clr[k][i]) |=> ev_pend[k][i]); // R4
        end
    end

    always_comb begin
        irq = '0;
        for (int k = 0; k < NUM_EV; k++)
            irq = irq | (ev_pend[k] & ev_en[k]);
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_edge_chk
        AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
            $rose(ev_pend[int'(EV_RISE)][i]) |-> $rose(level_q[i])); // R5
        AST_FALL_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
            $rose(ev_pend[int'(EV_FALL)][i]) |-> $fell(level_q[i])); // R5
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_ext,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] irq,
    output logic [NUM_PINS-1:0] pin_short
);

    logic [NUM_PINS-1:0]             in_en_q;
    logic [NUM_PINS-1:0]             out_en_q;
    logic [NUM_PINS-1:0]             out_val_q;
    logic [NUM_PINS-1:0]             out_inv_q;
    logic [NUM_PINS-1:0]             pull_en_q;
    logic [NUM_EV-1:0][NUM_PINS-1:0] ev_en_q;
    logic [NUM_EV-1:0][NUM_PINS-1:0] ev_clr;
    logic [NUM_EV-1:0][NUM_PINS-1:0] ev_pend;
    logic [NUM_PINS-1:0]             sample_now;
    logic [NUM_PINS-1:0]             level_q;

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_en_q   (in_en_q),
        .out_en_q  (out_en_q),
        .out_val_q (out_val_q),
        .out_inv_q (out_inv_q),
        .pull_en_q (pull_en_q),
        .ev_en_q   (ev_en_q),
        .ev_clr    (ev_clr),
        .level_q   (level_q),
        .ev_pend   (ev_pend)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg = '{in_en:   in_en_q[i],
                       out_en:  out_en_q[i],
                       out_val: out_val_q[i],
                       out_inv: out_inv_q[i],
                       pull_en: pull_en_q[i]};

        gpio_pin_slice i_slice (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg),
            .ext        (pin_ext[i]),
            .ext_val    (pin_in[i]),
            .pad_q      (pad_out[i]),
            .short_flag (pin_short[i]),
            .sample_now (sample_now[i]),
            .level_q    (level_q[i])
        );
    end

    gpio_irq_pend #(.NUM_PINS(NUM_PINS)) i_pend (
        .clk        (clk),
        .rst        (rst),
        .sample_now (sample_now),
        .level_q    (level_q),
        .ev_en      (ev_en_q),
        .ev_clr     (ev_clr),
        .ev_pend    (ev_pend),
        .irq        (irq)
    );

    assign pad_oe = out_en_q;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (ev_en_q == '0) |-> (irq == '0)); // R7

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_ext = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic [N-1:0]  irq;
    logic [N-1:0]  pin_short;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench copies of what it has written
    logic [31:0] sh_in_en = '0, sh_oe = '0, sh_val = '0, sh_inv = '0, sh_pull = '0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(N)) i_gpio_irq_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_ext(pin_ext), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq(irq), .pin_short(pin_short)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mdl_level();
        logic [31:0] r;
        for (int i = 0; i < N; i++) begin
            logic lv;
            if (pin_ext[i])    lv = pin_in[i];
            else if (sh_oe[i]) lv = sh_val[i] ^ sh_inv[i];
            else               lv = sh_pull[i];
            r[i] = sh_in_en[i] & lv;
        end
        return r;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        repeat (3) @(negedge clk);
        for (int a = 0; a <= 'h40; a += 4) begin
            rd(8'(a), d);
            check("R9", $sformatf("reg %02h in reset", a), d, 32'h0);
        end
        check("R9", "pad_out in reset", pad_out, '0);
        check("R9", "irq in reset", irq, '0);
        @(negedge clk);
        rst = 1'b0;
        settle();
        rd(8'h30, d);
        check("R4", "low pending after reset", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_output();
        sh_oe = 32'hFF; sh_val = 32'h0E; sh_inv = 32'h33;
        wr(8'h08, sh_oe); wr(8'h0C, sh_val); wr(8'h10, sh_inv);
        settle();
        check("R1", "pad_oe", pad_oe, 32'hFF);
        check("R1", "pad_out driven", pad_out, 32'h3D);
        sh_oe = 32'hFE; sh_val = 32'h0F;
        wr(8'h08, sh_oe); wr(8'h0C, sh_val);
        settle();
        check("R8", "pad_out bit0 held after disable", pad_out, 32'h3D);
    endtask

    task automatic t_resolve();
        logic [31:0] d;
        sh_in_en = 32'hFFFF_FFFF; sh_pull = 32'h0000_F001;
        wr(8'h04, sh_in_en); wr(8'h14, sh_pull);
        pin_ext = 32'h0000_00F0; pin_in = 32'h0000_0050;
        settle();
        rd(8'h00, d);
        check("R2", "level priority", d, mdl_level());
        check("R2", "level literal", d, 32'h0000_F05D);
        check("R8", "pad_out follows external", pad_out, 32'h5D);
        check("R11", "contention flags", pin_short, 32'hF0);
        sh_in_en = 32'h0000_FF00;
        wr(8'h04, sh_in_en);
        settle();
        rd(8'h00, d);
        check("R3", "level masked by input enable", d, 32'h0000_F000);
        wr(8'h00, 32'hFFFF_FFFF);
        settle();
        rd(8'h00, d);
        check("R3", "level ignores writes", d, 32'h0000_F000);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        sh_in_en = 32'hFFFF_FFFF;
        wr(8'h04, sh_in_en);
        settle();
        for (int k = 0; k < 4; k++) wr(8'(8'h28 + 8 * k), 32'hFFFF_FFFF);
        settle();
        rd(8'h28, d); check("R4", "high pending = level", d, 32'h0000_F05D);
        rd(8'h30, d); check("R4", "low pending = ~level", d, 32'hFFFF_0FA2);
        rd(8'h38, d); check("R6", "rise cleared", d, 32'h0);
        rd(8'h40, d); check("R6", "fall cleared", d, 32'h0);
        pin_ext[20] = 1'b1; pin_in[20] = 1'b1;
        settle();
        rd(8'h38, d); check("R5", "rise on pin 20", d, 32'h0010_0000);
        rd(8'h40, d); check("R5", "no fall yet", d, 32'h0);
        pin_in[20] = 1'b0;
        settle();
        rd(8'h40, d); check("R5", "fall on pin 20", d, 32'h0010_0000);
        rd(8'h38, d); check("R5", "rise sticky", d, 32'h0010_0000);
        rd(8'h28, d); check("R4", "high sticky", d, 32'h0010_F05D);
        wr(8'h28, 32'h0010_0000);
        rd(8'h28, d); check("R6", "high bit cleared", d, 32'h0000_F05D);
        wr(8'h38, 32'h0);
        rd(8'h38, d); check("R6", "zero write keeps rise", d, 32'h0010_0000);
        wr(8'h30, 32'h0010_0000);
        rd(8'h30, d); check("R6", "set wins over clear", d & 32'h0010_0000, 32'h0010_0000);
    endtask

    task automatic t_irq();
        wr(8'h34, 32'h0010_0000);
        check("R7", "rise enable", irq, 32'h0010_0000);
        wr(8'h3C, 32'h0000_0001);
        check("R7", "fall enable on idle pin", irq, 32'h0010_0000);
        wr(8'h24, 32'h0000_0008);
        check("R7", "high enable", irq, 32'h0010_0008);
        wr(8'h38, 32'h0010_0000);
        check("R7", "rise cleared", irq, 32'h0000_0008);
        wr(8'h2C, 32'h0000_0002);
        check("R7", "low enable", irq, 32'h0000_000A);
    endtask

    task automatic t_storage();
        logic [31:0] d;
        wr(8'h18, 32'hA5A5_A5A5); wr(8'h1C, 32'h1234_5678); wr(8'h20, 32'hCAFE_F00D);
        rd(8'h18, d); check("R10", "drive readback", d, 32'hA5A5_A5A5);
        rd(8'h1C, d); check("R10", "alt enable readback", d, 32'h1234_5678);
        rd(8'h20, d); check("R10", "alt select readback", d, 32'hCAFE_F00D);
        settle();
        check("R10", "storage has no pad effect", pad_out, 32'h5D);
        rd(8'h44, d); check("R10", "unmapped 44", d, 32'h0);
        rd(8'h7C, d); check("R10", "unmapped 7C", d, 32'h0);
        rd(8'h0A, d); check("R10", "misaligned 0A", d, 32'h0);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h09, 32'h0);
        rd(8'h08, d); check("R10", "oe after stray writes", d, sh_oe);
        rd(8'h0C, d); check("R12", "value offset 0C", d, sh_val);
        rd(8'h10, d); check("R12", "inversion offset 10", d, sh_inv);
        rd(8'h14, d); check("R12", "pull offset 14", d, sh_pull);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_output();
        t_resolve();
        t_pending();
        t_irq();
        t_storage();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule